// File: doc/BRIEF.md
# Bank-Switchable Two-Port Word Memory

This block is a two-port word store divided into four equal banks. At any moment each bank belongs to exactly one of the two ports, a left port and a right port. One external select bit per bank decides which port that is. Each port has its own chip enables, write strobe, output enable, byte-lane enables, bank number and in-bank word address. A port reaches only the banks it currently owns, so the two ports never contend for the same storage, and they can work in different banks in the same clock.

The model is synchronous on one clock, and read data is registered. A read or write aimed at a bank the port does not own is dropped. When that happens the port raises an access-denied flag for one cycle and returns a zero word.

The in-bank address width is a parameter. Its default of 9 keeps the default build small; a full-size build of four 8K-word banks sets it to 13. Every interface pin here is plain control or data. There is no streaming handshake, because every access completes in a fixed number of cycles.

Top module: `banked_dpram`

## Requirements
- R1: While `rst_n` is low, both read data outputs are zero and both denied flags are low.
- R2: Bank b is owned by the left port when `bank_sel[b]` is 0 and by the right port when it is 1; only the owner's accesses reach that bank.
- R3: A port accesses a bank only when both of its chip enables are active: `ce0_n` low and `ce1` high.
- R4: A write (`we_n` low) to an owned bank updates only the active-low enabled byte lanes: `lb_n` guards bits 7:0 and `ub_n` guards bits 15:8.
- R5: A read (`we_n` high) of an owned bank presents the addressed word on `rdata` after the next rising clock edge. Lanes whose byte enable was inactive when the read was sampled read as zero.
- R6: `rdata` is zero whenever `oe_n` is high; `oe_n` gates the registered word with no added clock delay.
- R7: An enabled read or write to a bank the port does not own leaves storage unchanged, returns zero data, and sets `deny` high for the following cycle.
- R8: `rdata` is zero in any cycle that follows a clock edge with no granted read, including after a write.
- R9: The four banks hold separate storage at the same in-bank address. Both ports may complete accesses to different banks in the same clock.
- R10: Moving a bank's select bit hands the bank over with its contents intact, and the change takes effect from the next sampled access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 4 | Per-bank owner: 0 left, 1 right |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_ba | input | 2 | Left bank number |
| l_addr | input | BANK_AW | Left in-bank word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_deny | output | 1 | Left access-denied pulse |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_ba | input | 2 | Right bank number |
| r_addr | input | BANK_AW | Right in-bank word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_deny | output | 1 | Right access-denied pulse |

## Verification
The assertions assume that every input holds a known value after reset and that `bank_sel` changes only between clock edges. The single-owner checks hold only under that assumption. The stimulus changes every input, including the select bits, half a cycle away from the sampling edge. It reads only words written earlier in the run, so no read returns uninitialised storage. Denied accesses and handovers are placed right next to ordinary reads and writes, so the one-cycle flag and the preserved contents can be observed at the ports.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int WORD_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int NPORT  = 2;

  typedef enum logic { SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1 } side_e;
endpackage

// File: rtl/bsdp_port_ctl.sv
module bsdp_port_ctl import bsdp_pkg::*; #(
  parameter int NBANK = 4,
  parameter int BA_W  = 2,
  parameter bit SIDE  = 1'b0
) (
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [NBANK-1:0] bank_sel,
  output logic [NBANK-1:0] wr_hit,
  output logic             rd_go,
  output logic             deny_now
);
  logic enabled;
  logic owned;
  logic granted;

  assign enabled  = !ce0_n && ce1;
  assign owned    = (bank_sel[ba] == SIDE);
  assign granted  = enabled && owned;
  assign rd_go    = granted && we_n;
  assign deny_now = enabled && !owned;

  always_comb begin
    wr_hit = '0;
    if (granted && !we_n) wr_hit[ba] = 1'b1;
  end
endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank import bsdp_pkg::*; #(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owner_r,
  input  logic              l_wr,
  input  logic [LANES-1:0]  l_lane,
  input  logic [AW-1:0]     l_addr,
  input  logic [WORD_W-1:0] l_wdata,
  input  logic              r_wr,
  input  logic [LANES-1:0]  r_lane,
  input  logic [AW-1:0]     r_addr,
  input  logic [WORD_W-1:0] r_wdata,
  output logic [WORD_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] store [DEPTH];
  logic              wr;
  logic [LANES-1:0]  lane;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] wdata;

  assign wr    = owner_r ? r_wr    : l_wr;
  assign lane  = owner_r ? r_lane  : l_lane;
  assign addr  = owner_r ? r_addr  : l_addr;
  assign wdata = owner_r ? r_wdata : l_wdata;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr && lane[g])
        store[addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    q <= store[addr];
  end

  // R2: only one port may write a bank, and only the port that owns it
  a_r2_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l_wr, r_wr}));
  a_r2_left_owner: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr |-> !owner_r);
  a_r2_right_owner: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr |-> owner_r);
endmodule

// File: rtl/banked_dpram.sv
module banked_dpram import bsdp_pkg::*; #(
  parameter  int BANK_AW = 9,
  parameter  int NBANK   = 4,
  localparam int BA_W    = $clog2(NBANK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBANK-1:0]   bank_sel,
  input  logic               l_ce0_n,
  input  logic               l_ce1,
  input  logic               l_we_n,
  input  logic               l_oe_n,
  input  logic               l_ub_n,
  input  logic               l_lb_n,
  input  logic [BA_W-1:0]    l_ba,
  input  logic [BANK_AW-1:0] l_addr,
  input  logic [WORD_W-1:0]  l_wdata,
  output logic [WORD_W-1:0]  l_rdata,
  output logic               l_deny,
  input  logic               r_ce0_n,
  input  logic               r_ce1,
  input  logic               r_we_n,
  input  logic               r_oe_n,
  input  logic               r_ub_n,
  input  logic               r_lb_n,
  input  logic [BA_W-1:0]    r_ba,
  input  logic [BANK_AW-1:0] r_addr,
  input  logic [WORD_W-1:0]  r_wdata,
  output logic [WORD_W-1:0]  r_rdata,
  output logic               r_deny
);
  logic               ce0_n_a [NPORT];
  logic               ce1_a   [NPORT];
  logic               we_n_a  [NPORT];
  logic               oe_n_a  [NPORT];
  logic [LANES-1:0]   lane_a  [NPORT];
  logic [BA_W-1:0]    ba_a    [NPORT];
  logic [BANK_AW-1:0] addr_a  [NPORT];
  logic [WORD_W-1:0]  wdata_a [NPORT];
  logic [WORD_W-1:0]  rdata_a [NPORT];
  logic               deny_a  [NPORT];

  logic [NBANK-1:0]   wr_hit   [NPORT];
  logic               rd_go    [NPORT];
  logic               deny_now [NPORT];
  logic [WORD_W-1:0]  bank_q   [NBANK];

  assign ce0_n_a[0] = l_ce0_n;  assign ce0_n_a[1] = r_ce0_n;
  assign ce1_a[0]   = l_ce1;    assign ce1_a[1]   = r_ce1;
  assign we_n_a[0]  = l_we_n;   assign we_n_a[1]  = r_we_n;
  assign oe_n_a[0]  = l_oe_n;   assign oe_n_a[1]  = r_oe_n;
  assign lane_a[0]  = ~{l_ub_n, l_lb_n};
  assign lane_a[1]  = ~{r_ub_n, r_lb_n};
  assign ba_a[0]    = l_ba;     assign ba_a[1]    = r_ba;
  assign addr_a[0]  = l_addr;   assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;  assign wdata_a[1] = r_wdata;
  assign l_rdata    = rdata_a[0];
  assign r_rdata    = rdata_a[1];
  assign l_deny     = deny_a[0];
  assign r_deny     = deny_a[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bsdp_bank #(.AW(BANK_AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .owner_r (bank_sel[b]),
      .l_wr    (wr_hit[0][b]),
      .l_lane  (lane_a[0]),
      .l_addr  (addr_a[0]),
      .l_wdata (wdata_a[0]),
      .r_wr    (wr_hit[1][b]),
      .r_lane  (lane_a[1]),
      .r_addr  (addr_a[1]),
      .r_wdata (wdata_a[1]),
      .q       (bank_q[b])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit SIDE = (p == 1);

    logic              rd_ok_q;
    logic [BA_W-1:0]   rd_ba_q;
    logic [LANES-1:0]  rd_lane_q;
    logic              deny_q;
    logic [WORD_W-1:0] masked;

    bsdp_port_ctl #(.NBANK(NBANK), .BA_W(BA_W), .SIDE(SIDE)) u_ctl (
      .ce0_n    (ce0_n_a[p]),
      .ce1      (ce1_a[p]),
      .we_n     (we_n_a[p]),
      .ba       (ba_a[p]),
      .bank_sel (bank_sel),
      .wr_hit   (wr_hit[p]),
      .rd_go    (rd_go[p]),
      .deny_now (deny_now[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_ok_q   <= 1'b0;
        rd_ba_q   <= '0;
        rd_lane_q <= '0;
        deny_q    <= 1'b0;
      end else begin
        rd_ok_q   <= rd_go[p];
        rd_ba_q   <= ba_a[p];
        rd_lane_q <= lane_a[p];
        deny_q    <= deny_now[p];
      end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign masked[g*LANE_W +: LANE_W] =
        rd_lane_q[g] ? bank_q[rd_ba_q][g*LANE_W +: LANE_W] : '0;
    end

    assign rdata_a[p] = (rd_ok_q && !oe_n_a[p]) ? masked : '0;
    assign deny_a[p]  = deny_q;

    // R5/R6: nonzero data needs an enabled read on the previous edge and oe_n low now
    a_r5_data_source: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_a[p] != '0) |-> ($past(!ce0_n_a[p] && ce1_a[p] && we_n_a[p]) && !oe_n_a[p]));
    // R7: a denied flag traces back to an enabled access to a bank owned by the other port
    a_r7_deny_cause: assert property (@(posedge clk) disable iff (!rst_n)
      deny_a[p] |-> $past(!ce0_n_a[p] && ce1_a[p] && (bank_sel[ba_a[p]] != SIDE)));
    // R7: a denied access returns no data
    a_r7_deny_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      deny_a[p] |-> (rdata_a[p] == '0));
    // R3: with a chip enable inactive the port neither writes nor reports denial
    a_r3_chip_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ce0_n_a[p] || !ce1_a[p]) |=> (!deny_a[p] && (rdata_a[p] == '0)));
  end
endmodule

// File: tb/sim_banked_dpram.sv
module sim_banked_dpram;
  localparam int AW = 9;

  typedef struct packed {
    logic        side;
    logic [3:0]  sel;
    logic        wr;
    logic [1:0]  ba;
    logic [8:0]  addr;
    logic [1:0]  be_n;   // {ub_n, lb_n}
    logic [15:0] wd;
    logic [15:0] exp;
    logic        deny;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 1'b1, 2'd0, 9'h005, 2'b00, 16'h1234, 16'h0000, 1'b0}, // R4 L full write
    '{1'b0, 4'h0, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h1234, 1'b0}, // R5 L read
    '{1'b1, 4'h0, 1'b1, 2'd0, 9'h005, 2'b00, 16'hFFFF, 16'h0000, 1'b1}, // R7 R write denied
    '{1'b0, 4'h0, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h1234, 1'b0}, // R7 storage kept
    '{1'b1, 4'h1, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h1234, 1'b0}, // R10 handover
    '{1'b1, 4'h1, 1'b1, 2'd0, 9'h005, 2'b10, 16'hABCD, 16'h0000, 1'b0}, // R4 low lane
    '{1'b1, 4'h1, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h12CD, 1'b0}, // R4 check
    '{1'b1, 4'h1, 1'b1, 2'd0, 9'h005, 2'b01, 16'h56EF, 16'h0000, 1'b0}, // R4 high lane
    '{1'b1, 4'h1, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h56CD, 1'b0}, // R4 check
    '{1'b1, 4'h1, 1'b0, 2'd0, 9'h005, 2'b01, 16'h0000, 16'h5600, 1'b0}, // R5 lane mask
    '{1'b0, 4'h1, 1'b0, 2'd0, 9'h005, 2'b00, 16'h0000, 16'h0000, 1'b1}, // R2/R7 L denied
    '{1'b0, 4'h1, 1'b1, 2'd1, 9'h005, 2'b00, 16'h1111, 16'h0000, 1'b0}, // R9 bank1 write
    '{1'b0, 4'h1, 1'b0, 2'd1, 9'h005, 2'b00, 16'h0000, 16'h1111, 1'b0}, // R9 bank1 read
    '{1'b1, 4'hF, 1'b1, 2'd3, 9'h1FF, 2'b00, 16'h7777, 16'h0000, 1'b0}, // R2 top address
    '{1'b1, 4'hF, 1'b0, 2'd3, 9'h1FF, 2'b00, 16'h0000, 16'h7777, 1'b0}  // R2 read back
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_sel = '0;
  logic        l_ce0_n = 1'b1, l_ce1 = 1'b0, l_we_n = 1'b1, l_oe_n = 1'b0;
  logic        l_ub_n = 1'b0, l_lb_n = 1'b0;
  logic [1:0]  l_ba = '0;
  logic [AW-1:0] l_addr = '0;
  logic [15:0] l_wdata = '0;
  logic [15:0] l_rdata;
  logic        l_deny;
  logic        r_ce0_n = 1'b1, r_ce1 = 1'b0, r_we_n = 1'b1, r_oe_n = 1'b0;
  logic        r_ub_n = 1'b0, r_lb_n = 1'b0;
  logic [1:0]  r_ba = '0;
  logic [AW-1:0] r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic [15:0] r_rdata;
  logic        r_deny;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_dpram #(.BANK_AW(AW), .NBANK(4)) u0 (
    .clk, .rst_n, .bank_sel,
    .l_ce0_n, .l_ce1, .l_we_n, .l_oe_n, .l_ub_n, .l_lb_n, .l_ba, .l_addr,
    .l_wdata, .l_rdata, .l_deny,
    .r_ce0_n, .r_ce1, .r_we_n, .r_oe_n, .r_ub_n, .r_lb_n, .r_ba, .r_addr,
    .r_wdata, .r_rdata, .r_deny
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_ce0_n = 1'b1; l_ce1 = 1'b0; l_we_n = 1'b1;
    r_ce0_n = 1'b1; r_ce1 = 1'b0; r_we_n = 1'b1;
  endtask

  task automatic drive(input logic side, input logic wr, input logic [1:0] ba,
                       input logic [8:0] addr, input logic [1:0] be_n,
                       input logic [15:0] wd);
    if (!side) begin
      l_ce0_n = 1'b0; l_ce1 = 1'b1; l_we_n = !wr; l_ba = ba; l_addr = addr;
      {l_ub_n, l_lb_n} = be_n; l_wdata = wd;
    end else begin
      r_ce0_n = 1'b0; r_ce1 = 1'b1; r_we_n = !wr; r_ba = ba; r_addr = addr;
      {r_ub_n, r_lb_n} = be_n; r_wdata = wd;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 l_rdata", l_rdata, 16'h0);
    check("R1 r_rdata", r_rdata, 16'h0);
    check("R1 deny", {14'h0, l_deny, r_deny}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      idle();
      bank_sel = VECS[i].sel;
      drive(VECS[i].side, VECS[i].wr, VECS[i].ba, VECS[i].addr, VECS[i].be_n, VECS[i].wd);
      @(negedge clk);
      if (VECS[i].side) begin
        check($sformatf("R5/R7 vec%0d rdata", i), r_rdata, VECS[i].exp);
        check($sformatf("R7 vec%0d deny", i), {15'h0, r_deny}, {15'h0, VECS[i].deny});
      end else begin
        check($sformatf("R5/R7 vec%0d rdata", i), l_rdata, VECS[i].exp);
        check($sformatf("R7 vec%0d deny", i), {15'h0, l_deny}, {15'h0, VECS[i].deny});
      end
    end

    // R8: idle cycle after a read gives zero
    idle();
    @(negedge clk);
    check("R8 idle r_rdata", r_rdata, 16'h0);
    check("R7 deny one cycle", {15'h0, r_deny}, 16'h0);

    // R6: oe_n high hides data, lowering it shows the registered word at once
    bank_sel = 4'hF;
    r_oe_n = 1'b1;
    drive(1'b1, 1'b0, 2'd3, 9'h1FF, 2'b00, 16'h0);
    @(negedge clk);
    check("R6 oe_n high", r_rdata, 16'h0);
    r_oe_n = 1'b0;
    #1;
    check("R6 oe_n low", r_rdata, 16'h7777);

    // R3: each chip enable inactive blocks a write
    idle();
    bank_sel = 4'h0;
    drive(1'b0, 1'b1, 2'd1, 9'h005, 2'b00, 16'hDEAD);
    l_ce1 = 1'b0;
    @(negedge clk);
    check("R3 ce1 low no deny", {15'h0, l_deny}, 16'h0);
    drive(1'b0, 1'b1, 2'd1, 9'h005, 2'b00, 16'hBEEF);
    l_ce0_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd1, 9'h005, 2'b00, 16'h0);
    @(negedge clk);
    check("R3 word kept", l_rdata, 16'h1111);

    // R8: a write cycle returns zero
    drive(1'b0, 1'b1, 2'd2, 9'h010, 2'b00, 16'hAAAA);
    @(negedge clk);
    check("R8 write cycle rdata", l_rdata, 16'h0);

    // R9: both ports in different banks on the same edge
    bank_sel = 4'b1000;
    drive(1'b0, 1'b1, 2'd0, 9'h010, 2'b00, 16'h0A0A);
    drive(1'b1, 1'b1, 2'd3, 9'h010, 2'b00, 16'h0B0B);
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 9'h010, 2'b00, 16'h0);
    drive(1'b1, 1'b0, 2'd3, 9'h010, 2'b00, 16'h0);
    @(negedge clk);
    check("R9 left bank0", l_rdata, 16'h0A0A);
    check("R9 right bank3", r_rdata, 16'h0B0B);
    drive(1'b0, 1'b0, 2'd2, 9'h010, 2'b00, 16'h0);
    @(negedge clk);
    check("R9 bank2 separate", l_rdata, 16'hAAAA);
    idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule